// File: doc/BRIEF.md
# Page Write Load Controller

This block sits on the write side of a byte-wide nonvolatile memory model. It watches a sampled parallel bus made of a 16-bit address, 8-bit data and three active-low controls (chip enable, output enable, write enable). Each qualifying write strobe drops one byte into a page buffer. The first byte fixes the page, which is the upper address bits above the in-page offset. Every later byte must fall in that same page.

No command starts or ends a page. The page stays open while new strobes keep arriving inside a load window that is counted in clock cycles. When the window runs out, the block copies only the loaded slots to a backing array through a simple write port, scanning them in ascending offset order. It then stays busy for the rest of a fixed programming period before it will accept another page. The window length, the programming length and the glitch-filter length are all parameters given in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: A bus sample is write-active only when `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe with `oe_n` low, or one with `ce_n` high, loads nothing and leaves `busy` low.
- R2: A strobe takes its address from its first write-active sample (the later of the two enables to fall). It takes its data from its last write-active sample (just before the earlier enable rises).
- R3: A strobe with fewer than MIN_LOW consecutive write-active samples is discarded.
- R4: `busy` rises in the cycle after the final active sample of the first accepted strobe. It stays high until the programming period ends.
- R5: The page closes once WIN_CYC cycles have passed since the first active sample of the most recent accepted strobe, provided no strobe is in progress. Any strobe that starts before the page closes joins the open page.
- R6: Within an open page, a strobe whose address bits 15..7 differ from the page is rejected. It writes nothing and does not restart the window.
- R7: Programming starts in the cycle after the page closes. For offset k = 0..127 in turn, one per cycle, `arr_we` is high in cycle k of the period only if slot k was loaded, with `arr_addr` = {page, k}.
- R8: Slots that were never loaded are not written, so the array keeps their old contents. A slot loaded twice commits its last data.
- R9: Programming lasts exactly PROG_CYC cycles. For a single strobe of L active samples, `busy` is therefore high for WIN_CYC + PROG_CYC − L cycles.
- R10: A strobe that starts or ends while programming runs is ignored.
- R11: During reset, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Byte address; bits 6..0 are the offset, bits 15..7 the page |
| din | input | 8 | Write data |
| busy | output | 1 | A page is open or being programmed |
| arr_we | output | 1 | Backing-array write strobe |
| arr_addr | output | 16 | Backing-array write address |
| arr_wdata | output | 8 | Backing-array write data |

## Verification
The hardest case to reach from the ports is a strobe that starts in one state and ends in another. One example is a strobe that begins while programming runs. Another is a strobe that arrives only a few cycles before the window closes. The bench reaches these by counting cycles from the start of each strobe. It places a second byte just inside the window, and places another byte a few cycles after the window has expired so that it falls inside the programming period. It also covers a chip-enable-controlled strobe whose address and data change in mid-pulse. A behavioural reference model, kept in queues and integers, predicts `busy` and the array port on every clock.

// File: rtl/page_load_ctrl.sv
`timescale 1ns/1ps
module page_load_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 7,
  parameter int MIN_LOW  = 2,
  parameter int WIN_CYC  = 20000,
  parameter int PROG_CYC = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int PAGE = 1 << OFF_W;
  localparam int PG_W = ADDR_W - OFF_W;
  localparam int WC_W = $clog2(WIN_CYC + 2);
  localparam int PC_W = $clog2(PROG_CYC + 1);
  localparam int LC_W = $clog2(MIN_LOW + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;
  st_t st;

  logic              act, act_q, armed, fin, ld_ok, take, expire, prog;
  logic [LC_W-1:0]   low_cnt;
  logic [WC_W-1:0]   since, win_age;
  logic [ADDR_W-1:0] a_hold;
  logic [DATA_W-1:0] d_hold;
  logic [PG_W-1:0]   page;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] pbuf [PAGE];
  logic [PAGE-1:0]   vld;
  logic [OFF_W:0]    idx;
  logic [PC_W-1:0]   pcnt;

  assign act    = ~ce_n & ~we_n & oe_n;
  assign fin    = act_q & ~act;
  assign prog   = (st == S_PROG);
  assign off    = a_hold[OFF_W-1:0];
  assign ld_ok  = fin & armed & ~prog & (low_cnt == LC_W'(MIN_LOW));
  assign take   = ld_ok & ((st == S_IDLE) | (a_hold[ADDR_W-1:OFF_W] == page));
  assign expire = (st == S_LOAD) & ~act_q & (win_age >= WC_W'(WIN_CYC));

  assign busy      = (st != S_IDLE);
  assign arr_we    = prog & ~idx[OFF_W] & vld[idx[OFF_W-1:0]];
  assign arr_addr  = {page, idx[OFF_W-1:0]};
  assign arr_wdata = pbuf[idx[OFF_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      armed   <= 1'b0;
      low_cnt <= '0;
      since   <= '0;
      a_hold  <= '0;
      d_hold  <= '0;
    end else begin
      act_q <= act;
      if (act & ~act_q) begin
        a_hold  <= addr;
        armed   <= ~prog;
        low_cnt <= LC_W'(1);
        since   <= WC_W'(1);
      end else begin
        if (act && low_cnt != LC_W'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
        if (since != WC_W'(WIN_CYC)) since <= since + 1'b1;
      end
      if (act) d_hold <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      page    <= '0;
      win_age <= '0;
      vld     <= '0;
      idx     <= '0;
      pcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st       <= S_LOAD;
          page     <= a_hold[ADDR_W-1:OFF_W];
          win_age  <= since + 1'b1;
          vld[off] <= 1'b1;
        end
        S_LOAD: begin
          if (take) begin
            win_age  <= since + 1'b1;
            vld[off] <= 1'b1;
          end else if (expire) begin
            st   <= S_PROG;
            idx  <= '0;
            pcnt <= '0;
          end else if (win_age < WC_W'(WIN_CYC)) begin
            win_age <= win_age + 1'b1;
          end
        end
        S_PROG: begin
          if (!idx[OFF_W]) idx <= idx + 1'b1;
          if (pcnt == PC_W'(PROG_CYC - 1)) begin
            st  <= S_IDLE;
            vld <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[off] <= d_hold;
  end
endmodule

// File: rtl/page_load_ctrl_chk.sv
`timescale 1ns/1ps
module page_load_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              ld_ok,
  input logic              prog,
  input logic [(1<<OFF_W)-1:0] vld
);
  p_load_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ok |-> ($past(oe_n) && !$past(we_n) && !$past(ce_n)));

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_ok));

  p_page_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFF_W]));

  p_we_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_scan_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));

  p_prog_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog && $past(prog)) |-> $stable(vld));
endmodule

bind page_load_ctrl page_load_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
  .ld_ok(ld_ok), .prog(prog), .vld(vld)
);

// File: tb/page_load_ctrl_test.sv
`timescale 1ns/1ps
module page_load_ctrl_test;
  localparam int OW = 7, PAGE = 128, ML = 2, WIN = 40, PROG = 200;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic        busy, arr_we;
  logic [15:0] arr_addr;
  logic [7:0]  arr_wdata;

  always #2.5 clk = ~clk;

  page_load_ctrl #(.ADDR_W(16), .DATA_W(8), .OFF_W(OW), .MIN_LOW(ML),
                   .WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  int checks = 0, fails = 0;
  int busy_cnt = 0, rises = 0;
  bit busy_q = 0;
  logic [7:0] dmem [int];

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // behavioural reference model
  int n = 0, phase = 0, s_start = 0, s_run = 0, last_start = 0, pg = 0, pstart = 0;
  bit pa = 0, s_arm = 0;
  logic [15:0] s_addr = '0;
  logic [7:0]  s_data = '0;
  logic [7:0]  mbuf [int];

  always @(posedge clk) begin : mdl
    bit a;
    int ph;
    a  = !ce_n && !we_n && oe_n;
    ph = phase;
    if (!rst_n) begin
      n = 0; phase = 0; pa = 0; s_run = 0; mbuf.delete();
    end else begin
      if (a && !pa) begin
        s_start = n; s_addr = addr; s_arm = (ph != 2); s_run = 0;
      end
      if (a) begin s_run++; s_data = din; end
      if (!a && pa) begin
        if (s_arm && ph != 2 && s_run >= ML) begin
          if (ph == 0) begin phase = 1; pg = int'(s_addr >> OW); end
          if (ph == 0 || int'(s_addr >> OW) == pg) begin
            mbuf[int'(s_addr) % PAGE] = s_data;
            last_start = s_start;
          end
        end
      end else if (ph == 1 && !pa && (n - last_start) >= WIN) begin
        phase = 2; pstart = n + 1;
      end
      if (ph == 2 && n == pstart + PROG - 1) begin
        phase = 0; mbuf.delete();
      end
      pa = a;
      n++;
    end
  end

  always @(negedge clk) begin : cmp
    int k;
    bit ew;
    if (rst_n) begin
      ew = 0; k = 0;
      if (phase == 2) begin
        k  = n - pstart;
        ew = (k < PAGE) && mbuf.exists(k);
      end
      chk("R4 R9 busy", busy, longint'(phase != 0));
      chk("R5 R7 arr_we", arr_we, longint'(ew));
      if (ew) begin
        chk("R7 arr_addr", arr_addr, pg * PAGE + k);
        chk("R2 R8 arr_wdata", arr_wdata, mbuf[k]);
      end
      if (arr_we) dmem[int'(arr_addr)] = arr_wdata;
      if (busy) busy_cnt++;
      if (busy && !busy_q) rises++;
      busy_q = busy;
    end
  end

  task automatic strobe(input logic [15:0] a, input logic [7:0] d, input int lo);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (lo) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic idle_wait;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int r0;
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", busy, 0);
    chk("R11 arr_we in reset", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R9: single byte, busy timing and length
    busy_cnt = 0;
    strobe(16'h1234, 8'h5A, 2);
    chk("R4 busy before final sample", busy, 0);
    @(negedge clk);
    chk("R4 busy after accept", busy, 1);
    idle_wait;
    chk("R9 busy length", busy_cnt, WIN + PROG - 2);
    chk("R7 committed byte", dmem[16'h1234], 8'h5A);

    // old content for R8
    strobe(16'h0307, 8'h11, 3);
    idle_wait;

    // R6 R8: page with rewrite, foreign page byte, unloaded slot
    strobe(16'h0305, 8'hA1, 2);
    strobe(16'h0306, 8'hB2, 2);
    strobe(16'h0406, 8'hEE, 2);
    strobe(16'h037F, 8'hC3, 2);
    strobe(16'h0305, 8'hD4, 2);
    idle_wait;
    chk("R8 last data for repeated slot", dmem[16'h0305], 8'hD4);
    chk("R7 slot 6", dmem[16'h0306], 8'hB2);
    chk("R7 top slot", dmem[16'h037F], 8'hC3);
    chk("R6 foreign page not written", longint'(dmem.exists(16'h0406)), 0);
    chk("R8 unloaded slot keeps value", dmem[16'h0307], 8'h11);

    // R3: short pulse
    r0 = rises;
    strobe(16'h2000, 8'h77, 1);
    repeat (5) @(negedge clk);
    chk("R3 glitch busy", busy, 0);
    chk("R3 glitch no op", rises, r0);

    // R1: output enable low, and chip enable high
    oe_n = 1'b0;
    strobe(16'h2001, 8'h78, 3);
    @(negedge clk);
    oe_n = 1'b1;
    addr = 16'h2002; we_n = 1'b0; ce_n = 1'b1;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 inhibited busy", busy, 0);
    chk("R1 inhibited no op", rises, r0);

    // R5: second byte just inside the window
    strobe(16'h5000, 8'h01, 2);
    repeat (WIN - 8) @(negedge clk);
    strobe(16'h5001, 8'h02, 2);
    idle_wait;
    chk("R5 one operation", rises, r0 + 1);
    chk("R5 late byte joined", dmem[16'h5001], 8'h02);

    // R10: byte after window expiry lands in programming
    strobe(16'h6000, 8'h03, 2);
    repeat (WIN + 5) @(negedge clk);
    chk("R10 programming active", busy, 1);
    strobe(16'h6001, 8'h04, 2);
    idle_wait;
    chk("R5 first byte committed", dmem[16'h6000], 8'h03);
    chk("R10 ignored byte", longint'(dmem.exists(16'h6001)), 0);
    chk("R10 no extra op", rises, r0 + 2);

    // R2: chip-enable-controlled strobe, address and data move mid-pulse
    @(negedge clk);
    we_n = 1'b0; addr = 16'h7010; din = 8'h00;
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);
    addr = 16'h7020; din = 8'h99;
    @(negedge clk);
    din = 8'h3C;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    idle_wait;
    chk("R2 address from first sample", dmem[16'h7010], 8'h3C);
    chk("R2 later address unused", longint'(dmem.exists(16'h7020)), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule